// File: doc/BRIEF.md
# DMA Two-Stage Channel Chaining Unit

This block lets the completion of one DMA channel start another DMA channel in hardware, with no software in between. It holds two independent chaining groups. Each group names a source channel, a destination channel and the kind of completion event on the source that should start the destination. Each group also has an enable. When the chosen event arrives on the source channel of an enabled group, the block sends a one-cycle start pulse to the destination channel.

Software programs each group through a small register port. Writes are masked: the register keeps every bit outside the mask and ORs in the write value. Because of this, the code that owns the source side and the code that owns the destination side can each write their own fields and the enable bit without disturbing the other side's fields. Reads return the whole register of the addressed group.

The channel engine drives one completion vector per event kind: fragment, block, transfer and linked-list. Each vector has one bit per channel. The block has no streaming data path, so none of its pins uses a valid/ready handshake and there is no back-pressure anywhere. Event inputs are sampled on every clock edge. A `ch_start` pulse must be consumed in the cycle it is high.

Top module: `chain2_link`

## Requirements
- R1: After reset, both group registers read 0 and `ch_start` is 0.
- R2: Group 0 is at address 0x28 and group 1 at 0x2c. A read of any other address returns 0, and a write to any other address changes no group.
- R3: A write to a group address makes the register `(old & ~wmask) | wdata`. Only the implemented bits are stored (mask 0x01FF3F3F); the other bits always read 0.
- R4: The group fields are:
  - bits 5:0: source channel;
  - bits 13:8: destination channel;
  - bits 19:16: trigger select (bit 16 fragment done, bit 17 block done, bit 18 transfer done, bit 19 linked-list done);
  - bits 23:20: interrupt mask, stored but unused;
  - bit 24: enable.

  A channel field holds the channel index plus one.
- R5: When a group is enabled and its selected event pulses on its source channel, `ch_start` has a bit set at the destination index one clock edge later. The pulse is one cycle wide for a one-cycle event.
- R6: A group whose enable bit is 0 never causes a start.
- R7: An event of a kind that is not selected, or an event on a channel other than the source, causes no start.
- R8: A trigger field that is 0, or that has more than one bit set, never causes a start.
- R9: A channel field that is 0 or greater than `NUM_CH` assigns no channel. A group with such a source or destination causes no start. Fields up to `NUM_CH` work, including the highest channel.
- R10: If both groups fire in the same cycle with the same destination, that destination gets one pulse. If their destinations differ, both destinations get a pulse in that cycle.
- R11: A write to the source fields and a later write to the destination fields of the same group each leave the other side's fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address for reads and writes |
| reg_wdata | input | 32 | Write value, ORed in after masking |
| reg_wmask | input | 32 | Bits to clear before the OR |
| reg_rdata | output | 32 | Combinational read of the addressed group |
| evt_frag | input | NUM_CH | Per-channel fragment-done pulses |
| evt_blk | input | NUM_CH | Per-channel block-done pulses |
| evt_xfer | input | NUM_CH | Per-channel transfer-done pulses |
| evt_list | input | NUM_CH | Per-channel linked-list-done pulses |
| ch_start | output | NUM_CH | Per-channel start pulses |

## Verification
An event that is driven in one cycle shows up on `ch_start` after the next rising edge. The bench therefore drives events at a falling edge and compares `ch_start` at the following falling edge. At the falling edge after that, it checks that `ch_start` has returned to 0, which confirms the pulse width. A write is applied at the rising edge inside its strobe cycle. The read port is combinational, so the bench reads back 1 ns after setting the address, on a later cycle. Every negative case checks `ch_start` at exactly the cycle in which a wrong start would appear.

// File: rtl/chain2_pkg.sv
package chain2_pkg;
  localparam int REG_W    = 32;
  localparam int CH_FW    = 6;
  localparam int SRC_LSB  = 0;
  localparam int DST_LSB  = 8;
  localparam int TRG_LSB  = 16;
  localparam int TRG_W    = 4;
  localparam int IMSK_LSB = 20;
  localparam int IMSK_W   = 4;
  localparam int EN_BIT   = 24;
  localparam logic [REG_W-1:0] IMPL_MASK = 32'h01FF_3F3F;

  typedef struct packed {
    logic             en;
    logic [TRG_W-1:0] trig;
    logic [CH_FW-1:0] dst;
    logic [CH_FW-1:0] src;
  } grp_fields_t;

  function automatic grp_fields_t unpack_grp(input logic [REG_W-1:0] r);
    grp_fields_t f;
    f.en   = r[EN_BIT];
    f.trig = r[TRG_LSB +: TRG_W];
    f.dst  = r[DST_LSB +: CH_FW];
    f.src  = r[SRC_LSB +: CH_FW];
    return f;
  endfunction
endpackage

// File: rtl/chain2_grp_reg.sv
module chain2_grp_reg
  import chain2_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int unsigned GRP_ADDR = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  reg_wmask,
  output logic [REG_W-1:0]  grp_q
);
  logic hit;
  assign hit = reg_we && (reg_addr == ADDR_W'(GRP_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else if (hit) begin
      grp_q <= ((grp_q & ~reg_wmask) | reg_wdata) & IMPL_MASK;
    end
  end
endmodule

// File: rtl/chain2_grp_fire.sv
module chain2_grp_fire
  import chain2_pkg::*;
#(
  parameter int NUM_CH = 16  // at most 63: channel fields are one-based 6-bit
) (
  input  logic [REG_W-1:0]  grp_q,
  input  logic [NUM_CH-1:0] evt_frag,
  input  logic [NUM_CH-1:0] evt_blk,
  input  logic [NUM_CH-1:0] evt_xfer,
  input  logic [NUM_CH-1:0] evt_list,
  output logic [NUM_CH-1:0] start_req
);
  grp_fields_t      f;
  logic             trig_ok;
  logic             src_hit;
  logic [NUM_CH-1:0] dst_vec;

  assign f       = unpack_grp(grp_q);
  assign trig_ok = (f.trig != '0) && ((f.trig & (f.trig - TRG_W'(1))) == '0);

  always_comb begin
    src_hit = 1'b0;
    dst_vec = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (f.src == CH_FW'(i + 1) &&
          |(f.trig & {evt_list[i], evt_xfer[i], evt_blk[i], evt_frag[i]}))
        src_hit = 1'b1;
      dst_vec[i] = (f.dst == CH_FW'(i + 1));
    end
    start_req = (f.en && trig_ok && src_hit) ? dst_vec : '0;
  end
endmodule

// File: rtl/chain2_link.sv
module chain2_link
  import chain2_pkg::*;
#(
  parameter int          NUM_CH   = 16,
  parameter int          NUM_GRP  = 2,
  parameter int          ADDR_W   = 8,
  parameter int unsigned BASE_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_wmask,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] evt_frag,
  input  logic [NUM_CH-1:0] evt_blk,
  input  logic [NUM_CH-1:0] evt_xfer,
  input  logic [NUM_CH-1:0] evt_list,
  output logic [NUM_CH-1:0] ch_start
);
  localparam int unsigned GRP_STRIDE = 4;

  logic [NUM_GRP-1:0][REG_W-1:0]  grp_q;
  logic [NUM_GRP-1:0][NUM_CH-1:0] grp_req;
  logic [NUM_CH-1:0]              start_d;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    chain2_grp_reg #(
      .ADDR_W  (ADDR_W),
      .GRP_ADDR(BASE_OFS + GRP_STRIDE * g)
    ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_wmask(reg_wmask),
      .grp_q    (grp_q[g])
    );

    chain2_grp_fire #(
      .NUM_CH(NUM_CH)
    ) u_fire (
      .grp_q    (grp_q[g]),
      .evt_frag (evt_frag),
      .evt_blk  (evt_blk),
      .evt_xfer (evt_xfer),
      .evt_list (evt_list),
      .start_req(grp_req[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    start_d   = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_addr == ADDR_W'(BASE_OFS + GRP_STRIDE * g))
        reg_rdata = reg_rdata | grp_q[g];
      start_d = start_d | grp_req[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_start <= '0;
    else        ch_start <= start_d;
  end
endmodule

// File: rtl/chain2_link_chk.sv
module chain2_link_chk
  import chain2_pkg::*;
#(
  parameter int          NUM_CH   = 16,
  parameter int          NUM_GRP  = 2,
  parameter int          ADDR_W   = 8,
  parameter int unsigned BASE_OFS = 'h28
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            reg_we,
  input logic [ADDR_W-1:0]               reg_addr,
  input logic [31:0]                     reg_wdata,
  input logic [31:0]                     reg_wmask,
  input logic [NUM_GRP-1:0][REG_W-1:0]   grp_q,
  input logic [NUM_CH-1:0]               evt_frag,
  input logic [NUM_CH-1:0]               evt_blk,
  input logic [NUM_CH-1:0]               evt_xfer,
  input logic [NUM_CH-1:0]               evt_list,
  input logic [NUM_CH-1:0]               ch_start
);
  logic any_evt;
  logic any_en;
  assign any_evt = |{evt_frag, evt_blk, evt_xfer, evt_list};
  always_comb begin
    any_en = 1'b0;
    for (int g = 0; g < NUM_GRP; g++) any_en = any_en | grp_q[g][EN_BIT];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] GA = ADDR_W'(BASE_OFS + 4 * g);

    assert_keep_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == GA) |=>
        ((grp_q[g] & ~$past(reg_wmask)) ==
         (($past(grp_q[g]) | $past(reg_wdata)) & ~$past(reg_wmask) & IMPL_MASK)));

    assert_hold_unaddressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == GA) |=> $stable(grp_q[g]));
  end

  assert_start_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |-> $past(any_en));

  assert_start_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |-> $past(any_evt));

  assert_start_per_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_start) <= NUM_GRP);
endmodule

bind chain2_link chain2_link_chk #(
  .NUM_CH  (NUM_CH),
  .NUM_GRP (NUM_GRP),
  .ADDR_W  (ADDR_W),
  .BASE_OFS(BASE_OFS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_wmask(reg_wmask),
  .grp_q    (grp_q),
  .evt_frag (evt_frag),
  .evt_blk  (evt_blk),
  .evt_xfer (evt_xfer),
  .evt_list (evt_list),
  .ch_start (ch_start)
);

// File: tb/chain2_link_bench.sv
module chain2_link_bench;
  localparam int NCH = 16;
  localparam logic [7:0] G0 = 8'h28;
  localparam logic [7:0] G1 = 8'h2c;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [7:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_wmask = '0;
  logic [31:0]    reg_rdata;
  logic [NCH-1:0] evt_frag = '0, evt_blk = '0, evt_xfer = '0, evt_list = '0;
  logic [NCH-1:0] ch_start;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chain2_link u_chain2_link (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
    .evt_frag(evt_frag), .evt_blk(evt_blk), .evt_xfer(evt_xfer),
    .evt_list(evt_list), .ch_start(ch_start)
  );

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; reg_wmask = '0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    cmp(reg_rdata, exp, req);
  endtask

  // drive events for one cycle; check the start pulse and that it ends
  task automatic pulse(input logic [NCH-1:0] f, input logic [NCH-1:0] b,
                       input logic [NCH-1:0] x, input logic [NCH-1:0] l,
                       input logic [NCH-1:0] exp, input string req);
    @(negedge clk);
    evt_frag = f; evt_blk = b; evt_xfer = x; evt_list = l;
    @(negedge clk);
    evt_frag = '0; evt_blk = '0; evt_xfer = '0; evt_list = '0;
    cmp(32'(ch_start), 32'(exp), req);
    @(negedge clk);
    cmp(32'(ch_start), 32'h0, {req, " width"});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cmp(32'(ch_start), 32'h0, "R1 start");
    rd_chk(G0, 32'h0, "R1 group0");
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(G1, 32'h0, "R1 group1");
  endtask

  task automatic t_addr;
    wr(8'h30, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'h0, "R2 unmapped read");
    rd_chk(G0, 32'h0, "R2 group0 untouched");
    rd_chk(G1, 32'h0, "R2 group1 untouched");
  endtask

  task automatic t_split_write;
    // source side: src=3 (channel 2), block done, enable
    wr(G0, 32'h0102_0003, 32'h0102_0003);
    rd_chk(G0, 32'h0102_0003, "R11 source side");
    // destination side: dst=5 (channel 4), enable
    wr(G0, 32'h0100_0500, 32'h0100_0500);
    rd_chk(G0, 32'h0102_0503, "R11 both sides R4 layout");
  endtask

  task automatic t_fire;
    pulse('0, NCH'(1) << 2, '0, '0, NCH'(1) << 4, "R5 block done fires");
  endtask

  task automatic t_mismatch;
    pulse(NCH'(1) << 2, '0, NCH'(1) << 2, NCH'(1) << 2, '0, "R7 wrong kind");
    pulse('0, NCH'(1) << 3, '0, '0, '0, "R7 wrong channel");
  endtask

  task automatic t_disable;
    wr(G0, 32'h0, 32'h0100_0000);
    rd_chk(G0, 32'h0002_0503, "R6 enable cleared");
    pulse('0, NCH'(1) << 2, '0, '0, '0, "R6 disabled");
    wr(G0, 32'h0100_0000, 32'h0100_0000);
  endtask

  task automatic t_trig_bad;
    wr(G1, 32'h0100_0701, 32'hFFFF_FFFF);
    pulse(NCH'(1), NCH'(1), NCH'(1), NCH'(1), '0, "R8 zero trigger");
    wr(G1, 32'h0103_0701, 32'hFFFF_FFFF);
    pulse(NCH'(1), NCH'(1), '0, '0, '0, "R8 two trigger bits");
  endtask

  task automatic t_range;
    wr(G1, 32'h0108_0714, 32'hFFFF_FFFF);
    pulse('0, '0, '0, '1, '0, "R9 source out of range");
    wr(G1, 32'h0108_0001, 32'hFFFF_FFFF);
    pulse('0, '0, '0, '1, '0, "R9 zero destination");
    wr(G1, 32'h0104_1010, 32'hFFFF_FFFF);
    pulse('0, '0, NCH'(1) << 15, '0, NCH'(1) << 15, "R9 highest channel");
  endtask

  task automatic t_merge;
    wr(G1, 32'h0104_0501, 32'hFFFF_FFFF);
    pulse('0, '0, NCH'(1), '0, NCH'(1) << 4, "R5 group1 transfer done");
    pulse('0, NCH'(1) << 2, NCH'(1), '0, NCH'(1) << 4, "R10 shared destination");
    wr(G1, 32'h0104_0901, 32'hFFFF_FFFF);
    pulse('0, NCH'(1) << 2, NCH'(1), '0, (NCH'(1) << 4) | (NCH'(1) << 8),
          "R10 distinct destinations");
  endtask

  task automatic t_mask_rule;
    wr(G0, 32'h00A0_0000, 32'h00F0_0000);
    rd_chk(G0, 32'h01A2_0503, "R3 masked field");
    wr(G0, 32'h8010_0040, 32'h0);
    rd_chk(G0, 32'h01B2_0503, "R3 OR without mask, unimplemented dropped");
    pulse('0, NCH'(1) << 2, '0, '0, NCH'(1) << 4, "R4 interrupt mask no effect");
  endtask

  initial begin
    t_reset();
    t_addr();
    t_split_write();
    t_fire();
    t_mismatch();
    t_disable();
    t_trig_bad();
    t_range();
    t_merge();
    t_mask_rule();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule